// File: doc/BRIEF.md
# Serial EEPROM Configuration Loader

This block runs once after reset. It reads a short list of 16-bit words from a small serial EEPROM over a four-wire chip-select, clock, data-out and data-in link, and it hands each word to the surrounding configuration registers. The serial clock is made by dividing the system clock by a fixed ratio. The loader sends one read command per word. Each command is a start bit, a two-bit read opcode and a six-bit word address. The loader then collects the sixteen data bits that the EEPROM shifts back.

Addresses are read in ascending order from zero. Each finished word appears for one cycle on a load strobe, together with its index. When the list is done, a done flag rises and stays high. The EEPROM data line is pulled up, so a missing device answers with all ones. If the first word comes back as all ones, the loader reports that no EEPROM is present, loads nothing and stops.

Top module: `cfgld_loader`

## Requirements
- R1: During a transfer, every high phase and every low phase of `ee_sclk` lasts exactly DIV/2 system clock cycles (18 with DIV=36), so the serial period is DIV cycles.
- R2: `ee_cs` rises exactly DIV/2 cycles before the first `ee_sclk` rising edge of a command. It falls exactly DIV/2 cycles after the last `ee_sclk` falling edge. `ee_sclk` is low whenever `ee_cs` is low.
- R3: `ee_di` changes only in the cycle where `ee_sclk` falls or `ee_cs` rises, so it is stable across every rising edge.
- R4: On serial rising edges 1 to 9 of a command, `ee_di` carries 1, 1, 0 and then the six-bit word address, most significant bit first.
- R5: `ee_do` is sampled in the cycle where `ee_sclk` rises. The value at rising edge 10 is a dummy bit and is discarded. Rising edges 11 to 26 give data bits 15 down to 0. A command has exactly 26 rising edges.
- R6: Words are read at addresses 0 up to NUM_WORDS-1 in order, with `ee_cs` low for at least DIV cycles between commands. Each word gives a one-cycle `ld_valid` in the first cycle with `ee_cs` low, with `ld_index` equal to the address and `ld_data` equal to the word.
- R7: After the last word, `done` rises and stays high, and no further command starts.
- R8: If word 0 reads as 16'hFFFF, `absent` and `done` rise, `ld_valid` never pulses, and no second command is issued.
- R9: An all-ones word at any address other than 0 is loaded normally.
- R10: During reset, `ee_cs`, `ee_sclk`, `ee_di`, `ld_valid`, `done` and `absent` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ee_cs | output | 1 | EEPROM chip select, active high |
| ee_sclk | output | 1 | Serial clock, system clock divided by DIV |
| ee_di | output | 1 | Serial command/address out to the EEPROM |
| ee_do | input | 1 | Serial data in from the EEPROM, pulled up |
| ld_valid | output | 1 | One-cycle load strobe for a finished word |
| ld_index | output | IDX_W | Word index (equal to EEPROM address) |
| ld_data | output | DATA_W | Word read from the EEPROM |
| done | output | 1 | Load sequence complete (sticky) |
| absent | output | 1 | First word read as all ones; nothing loaded |

## Verification
The bench places a behavioural EEPROM on the link and reads eight words under four content patterns. One pattern is a floating, pulled-up data line. It measures every phase width and the chip-select setup, hold and gap. A divider that is off by one would shift one of these widths and be reported. The bench targets the dummy-bit slot: a loader that samples one edge early or late returns every word shifted by one bit. It also targets the all-ones cases. A loader that checks every word for all ones would drop the legal 16'hFFFF at address 2. A loader that never checks would emit loads from an empty socket.

// File: rtl/cfgld_pkg.sv
// Shared definitions for the serial EEPROM configuration loader.
package cfgld_pkg;
    // Sequencer phases: idle gap, chip-select setup, bit transfer, finished
    typedef enum logic [1:0] {
        ST_GAP   = 2'd0,
        ST_SETUP = 2'd1,
        ST_XFER  = 2'd2,
        ST_DONE  = 2'd3
    } ld_state_t;

    // Start bit followed by the read opcode, sent ahead of the address
    localparam logic [2:0] READ_PREFIX = 3'b110;
endpackage

// File: rtl/cfgld_halftick.sv
// Half-period tick generator.
// Emits a one-cycle tick every HALF system clocks while run is high.
// Assumes HALF >= 2. The count restarts whenever run is low.
module cfgld_halftick #(
    parameter int HALF = 18
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0] cnt;

    // Count cycles within the current half period
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (cnt == CW'(HALF - 1)) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CW'(1);
        end
    end

    // Tick on the last cycle of each half period
    assign tick = run && (cnt == CW'(HALF - 1));
endmodule

// File: rtl/cfgld_cmd_tx.sv
// Read command shifter.
// load captures {start, opcode, address}; each shift moves the next bit to
// bit_out and fills with zeros, so the line idles low after the command.
module cfgld_cmd_tx #(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              shift,
    input  logic [ADDR_W-1:0] addr,
    output logic              bit_out
);
    import cfgld_pkg::*;

    localparam int CMD_W = 3 + ADDR_W;

    logic [CMD_W-1:0] sh;

    // Load a new command or advance one bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh <= '0;
        end else if (load) begin
            sh <= {READ_PREFIX, addr};
        end else if (shift) begin
            sh <= {sh[CMD_W-2:0], 1'b0};
        end
    end

    assign bit_out = sh[CMD_W-1];
endmodule

// File: rtl/cfgld_rx_capture.sv
// Serial data capture.
// Shifts din in at the LSB on each sample strobe, so the first bit sampled
// ends up as the MSB. clr empties the word before a new command.
module cfgld_rx_capture #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              sample,
    input  logic              din,
    output logic [DATA_W-1:0] word
);
    // Accumulate sampled bits MSB first
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            word <= '0;
        end else if (sample) begin
            word <= {word[DATA_W-2:0], din};
        end
    end
endmodule

// File: rtl/cfgld_loader.sv
// Serial EEPROM configuration loader (top).
// After reset it reads words 0..NUM_WORDS-1 with one read command each and
// presents every word on a one-cycle load strobe, then raises done.
// An all-ones first word means no device: absent is set and nothing loads.
// Assumes NUM_WORDS <= 2**ADDR_W and an even DIV >= 4.
module cfgld_loader #(
    parameter int DIV       = 36,
    parameter int NUM_WORDS = 4,
    parameter int ADDR_W    = 6,
    parameter int DATA_W    = 16,
    parameter int IDX_W     = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              ee_cs,
    output logic              ee_sclk,
    output logic              ee_di,
    input  logic              ee_do,
    output logic              ld_valid,
    output logic [IDX_W-1:0]  ld_index,
    output logic [DATA_W-1:0] ld_data,
    output logic              done,
    output logic              absent
);
    import cfgld_pkg::*;

    localparam int HALF       = DIV / 2;
    localparam int CMD_BITS   = 3 + ADDR_W;
    localparam int DUMMY_RISE = CMD_BITS + 1;
    localparam int RISES      = CMD_BITS + 1 + DATA_W;
    localparam int HALVES     = 2 * RISES;
    localparam int HC_W       = $clog2(HALVES + 1);
    localparam int FIRST_SMP  = 2 * DUMMY_RISE - 1;

    ld_state_t         state;
    logic [HC_W-1:0]   hcnt;
    logic [IDX_W-1:0]  idx;
    logic              tick;
    logic              tx_load, tx_shift, rx_sample;
    logic [DATA_W-1:0] rx_word;

    // Half-period timing only while the sequence is active
    cfgld_halftick #(.HALF(HALF)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state != ST_DONE),
        .tick  (tick)
    );

    // Decode the shift and sample strobes from the sequencer position
    always_comb begin
        tx_load   = tick && (state == ST_GAP) && (hcnt == HC_W'(1));
        tx_shift  = tick && (state == ST_XFER) && !hcnt[0];
        rx_sample = tick && (state == ST_XFER) && hcnt[0]
                    && (hcnt >= HC_W'(FIRST_SMP)) && (hcnt != HC_W'(HALVES - 1));
    end

    cfgld_cmd_tx #(.ADDR_W(ADDR_W)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tx_load),
        .shift   (tx_shift),
        .addr    (ADDR_W'(idx)),
        .bit_out (ee_di)
    );

    cfgld_rx_capture #(.DATA_W(DATA_W)) u_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (tx_load),
        .sample (rx_sample),
        .din    (ee_do),
        .word   (rx_word)
    );

    // Sequencer: gap, chip-select setup, 2*RISES half periods, then next word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_GAP;
            hcnt     <= '0;
            idx      <= '0;
            ee_cs    <= 1'b0;
            ee_sclk  <= 1'b0;
            ld_valid <= 1'b0;
            ld_index <= '0;
            absent   <= 1'b0;
        end else begin
            ld_valid <= 1'b0;
            if (tick) begin
                case (state)
                    ST_GAP: begin
                        if (hcnt == HC_W'(1)) begin
                            state <= ST_SETUP;
                            hcnt  <= '0;
                            ee_cs <= 1'b1;
                        end else begin
                            hcnt <= hcnt + HC_W'(1);
                        end
                    end
                    ST_SETUP: begin
                        state   <= ST_XFER;
                        hcnt    <= '0;
                        ee_sclk <= 1'b1;
                    end
                    ST_XFER: begin
                        if (hcnt == HC_W'(HALVES - 1)) begin
                            ee_cs <= 1'b0;
                            hcnt  <= '0;
                            if ((idx == '0) && (&rx_word)) begin
                                absent <= 1'b1;
                                state  <= ST_DONE;
                            end else begin
                                ld_valid <= 1'b1;
                                ld_index <= idx;
                                if (idx == IDX_W'(NUM_WORDS - 1)) begin
                                    state <= ST_DONE;
                                end else begin
                                    idx   <= idx + IDX_W'(1);
                                    state <= ST_GAP;
                                end
                            end
                        end else begin
                            ee_sclk <= hcnt[0];
                            hcnt    <= hcnt + HC_W'(1);
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign ld_data = rx_word;
    assign done    = (state == ST_DONE);
endmodule

// File: rtl/cfgld_loader_chk.sv
// Protocol checker for cfgld_loader, attached with bind below.
// Phase widths are tracked with counters, not deep $past.
module cfgld_loader_chk #(
    parameter int HALF = 18
) (
    input logic clk,
    input logic rst_n,
    input logic cs,
    input logic sclk,
    input logic di,
    input logic ld_valid,
    input logic done,
    input logic absent
);
    logic [15:0] hi_cnt;
    logic [15:0] lo_cnt;

    // Count consecutive high cycles, and low cycles with chip select active
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_cnt <= '0;
            lo_cnt <= '0;
        end else begin
            hi_cnt <= sclk ? hi_cnt + 16'd1 : 16'd0;
            lo_cnt <= (cs && !sclk) ? lo_cnt + 16'd1 : 16'd0;
        end
    end

    // R1: each high phase lasts HALF cycles
    a_r1_high_width: assert property (@(posedge clk) disable iff (!rst_n)
        (!sclk && $past(sclk)) |-> (hi_cnt == 16'(HALF)));

    // R1/R2: each low phase under chip select, including setup, lasts HALF cycles
    a_r2_low_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> (lo_cnt == 16'(HALF)));

    // R2: no serial clock without chip select
    a_r2_cs_gates_sclk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |-> !sclk);

    // R3: data out changes only at a falling edge or chip-select rise
    a_r3_di_launch: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(di) |-> ($fell(sclk) || $rose(cs)));

    // R6: load strobe is one cycle wide and coincides with chip-select release
    a_r6_load_at_release: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |-> ($fell(cs) && !$past(ld_valid)));

    // R7: done is sticky and nothing starts afterwards
    a_r7_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (done && !$rose(cs)));

    // R8: absent implies done and never a load
    a_r8_absent_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        absent |-> (done && !ld_valid));
endmodule

bind cfgld_loader cfgld_loader_chk #(.HALF(HALF)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs       (ee_cs),
    .sclk     (ee_sclk),
    .di       (ee_di),
    .ld_valid (ld_valid),
    .done     (done),
    .absent   (absent)
);

// File: tb/cfgld_loader_test.sv
`timescale 1ns/1ps
// Bench: behavioural EEPROM model plus protocol monitor, four content patterns.
module cfgld_loader_test;
    localparam int N    = 8;
    localparam int DIV  = 36;
    localparam int HALF = DIV / 2;
    localparam int IW   = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ee_cs, ee_sclk, ee_di;
    logic ee_do = 1'b1;
    logic ld_valid, done, absent;
    logic [IW-1:0] ld_index;
    logic [15:0]   ld_data;

    int checks = 0;
    int errors = 0;
    int mode = 0;
    bit model_en = 1'b1;

    // monitor state
    int cyc = 0, rise_cnt = 0, cmd_cnt = 0, loads = 0;
    int last_rise = 0, last_fall = 0, last_cs_rise = 0, last_cs_fall = 0;
    logic [8:0] cmd_cap = '0;
    logic prev_sclk = 1'b0, prev_cs = 1'b0, prev_di = 1'b0;

    always #2 clk = ~clk;

    cfgld_loader #(.DIV(DIV), .NUM_WORDS(N), .ADDR_W(6), .DATA_W(16)) uut (
        .clk(clk), .rst_n(rst_n), .ee_cs(ee_cs), .ee_sclk(ee_sclk), .ee_di(ee_di),
        .ee_do(ee_do), .ld_valid(ld_valid), .ld_index(ld_index), .ld_data(ld_data),
        .done(done), .absent(absent)
    );

    // EEPROM contents per pattern, computed arithmetically
    function automatic logic [15:0] mem_word(int m, int a);
        logic [15:0] base;
        base = 16'(a * 16'h1357) ^ 16'h8421;
        case (m)
            2: mem_word = (a == 0) ? 16'h0000 : (a == 2) ? 16'hFFFF :
                          (a == 5) ? 16'h8000 : base;
            3: mem_word = (a == 0) ? 16'hFFFF : base;
            default: mem_word = base;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Model and monitor, sampled on the falling clock edge
    always @(negedge clk) begin
        if (!rst_n) begin
            rise_cnt = 0; cmd_cnt = 0; loads = 0; cmd_cap = '0;
            prev_sclk = 1'b0; prev_cs = 1'b0; prev_di = 1'b0;
            ee_do = 1'b1;
        end else begin
            if (ee_di != prev_di)
                chk((ee_sclk == 1'b0 && prev_sclk) || (ee_cs && !prev_cs),
                    "R3 di launch", 32'(ee_di), 32'(prev_di));
            if (ee_cs && !prev_cs) begin
                if (cmd_cnt > 0)
                    chk(cyc - last_cs_fall >= DIV, "R6 cs gap", 32'(cyc - last_cs_fall), DIV);
                chk(!done, "R7 no command after done", 32'(done), 0);
                rise_cnt = 0; cmd_cap = '0; last_cs_rise = cyc;
                ee_do = 1'b1;
            end
            if (ee_sclk && !prev_sclk) begin
                chk(ee_cs, "R2 sclk under cs", 32'(ee_cs), 1);
                rise_cnt++;
                if (rise_cnt == 1)
                    chk(cyc - last_cs_rise == HALF, "R2 cs setup", 32'(cyc - last_cs_rise), HALF);
                else
                    chk(cyc - last_fall == HALF, "R1 low width", 32'(cyc - last_fall), HALF);
                if (rise_cnt <= 9) cmd_cap = {cmd_cap[7:0], ee_di};
                last_rise = cyc;
            end
            if (!ee_sclk && prev_sclk) begin
                chk(cyc - last_rise == HALF, "R1 high width", 32'(cyc - last_rise), HALF);
                last_fall = cyc;
                if (!model_en) ee_do = 1'b1;
                else if (rise_cnt == 9) ee_do = 1'b0;
                else if (rise_cnt >= 10 && rise_cnt <= 25)
                    ee_do = mem_word(mode, cmd_cnt)[15 - (rise_cnt - 10)];
                else ee_do = 1'b1;
            end
            if (!ee_cs && prev_cs) begin
                chk(cyc - last_fall == HALF, "R2 cs hold", 32'(cyc - last_fall), HALF);
                chk(rise_cnt == 26, "R5 rise count", 32'(rise_cnt), 26);
                chk(cmd_cap == {3'b110, 6'(cmd_cnt)}, "R4 command", 32'(cmd_cap),
                    32'({3'b110, 6'(cmd_cnt)}));
                cmd_cnt++;
                last_cs_fall = cyc;
                ee_do = 1'b1;
            end
            if (ld_valid) begin
                chk(!ee_cs && prev_cs, "R6 strobe at cs release", 32'(ee_cs), 0);
                chk(ld_index == IW'(loads), "R6 index", 32'(ld_index), 32'(loads));
                chk(ld_data == mem_word(mode, loads),
                    (mode == 2 && loads == 2) ? "R9 all-ones word" : "R5 data",
                    32'(ld_data), 32'(mem_word(mode, loads)));
                loads++;
            end
            prev_sclk = ee_sclk; prev_cs = ee_cs; prev_di = ee_di;
        end
        cyc++;
    end

    task automatic run_case(input int m, input int exp_loads, input int exp_cmds,
                            input bit exp_absent);
        mode = m;
        model_en = (m != 1);
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk({ee_cs, ee_sclk, ee_di, ld_valid, done, absent} == 6'b0,
            "R10 reset outputs", 32'({ee_cs, ee_sclk, ee_di, ld_valid, done, absent}), 0);
        rst_n = 1'b1;
        for (int i = 0; i < 20000 && !done; i++) @(negedge clk);
        repeat (200) @(negedge clk);
        chk(done, "R7 done", 32'(done), 1);
        chk(absent == exp_absent, "R8 absent flag", 32'(absent), 32'(exp_absent));
        chk(loads == exp_loads, "R8 load count", 32'(loads), 32'(exp_loads));
        chk(cmd_cnt == exp_cmds, "R6 command count", 32'(cmd_cnt), 32'(exp_cmds));
        chk(!ee_cs && !ee_sclk, "R7 link idle after done", 32'({ee_cs, ee_sclk}), 0);
    endtask

    initial begin
        run_case(0, N, N, 1'b0);   // ordinary contents
        run_case(1, 0, 1, 1'b1);   // R8: no device, pulled-up line
        run_case(2, N, N, 1'b0);   // zero word 0, all-ones word 2 (R9)
        run_case(3, 0, 1, 1'b1);   // R8: device present but word 0 all ones
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule